// File: doc/BRIEF.md
# VGA 640x480 Raster Timing Generator

This block paces a 640x480 raster from a 25 MHz pixel clock. A column counter runs through each 800-clock line, and a row counter steps once for every completed line of a 521-line frame. From these two counters the block produces several outputs:
- active-low horizontal and vertical sync,
- a display-enable flag,
- the current column and row,
- a single-cycle start-of-frame strobe.

An 8-bit colour input (3 red, 3 green, 2 blue) passes to the colour outputs only inside the visible window. Everywhere else the colour outputs are forced to zero.

Every output comes from a register, and all of them describe the same pixel position. The colour presented at the inputs in the cycle the counters sit on a given pixel leaves the block together with that pixel's column, row, enable and sync levels, one clock later. The four interval lengths of each axis are parameters. Their defaults are:
- Line: 640 visible, 16 front porch, 96 sync, 48 back porch.
- Frame: 480 visible, 10 front porch, 2 sync, 29 back porch.

Top module: `vga_raster_timing`

## Requirements
- R1: `col_o` advances by one every clock and wraps from line length minus one (799 by default) to 0.
- R2: `row_o` holds while `col_o` is not at its last value, advances by one when `col_o` wraps, and wraps from frame length minus one (520 by default) to 0.
- R3: `de_o` is 1 exactly when `col_o` is below the visible width and `row_o` is below the visible height.
- R4: `hsync_n_o` is 0 exactly when `col_o` lies in [visible width + front porch, visible width + front porch + sync width), i.e. columns 656 to 751 by default.
- R5: `vsync_n_o` is 0 exactly when `row_o` lies in [visible height + front porch, visible height + front porch + sync height), i.e. rows 490 and 491 by default, for whole lines.
- R6: The colour outputs equal the colour inputs sampled one clock earlier while `de_o` is 1, and are all zero while `de_o` is 0.
- R7: `sof_o` is 1 for exactly the one cycle in which `col_o` and `row_o` are both 0.
- R8: While `rst` is high the outputs show the last position of the frame (`col_o` = line length minus one, `row_o` = frame length minus one) with `de_o` = 0, both syncs at 1, `sof_o` = 0 and colour 0. The first clock after `rst` falls presents position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| red_i | input | RED_W (3) | Red component of the pixel at the current counter position |
| green_i | input | GRN_W (3) | Green component |
| blue_i | input | BLU_W (2) | Blue component |
| col_o | output | clog2(line length) | Column of the pixel now on the outputs |
| row_o | output | clog2(frame length) | Row of the pixel now on the outputs |
| de_o | output | 1 | Display enable, high in the visible window |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| sof_o | output | 1 | One-cycle strobe at position (0,0) |
| red_o | output | RED_W (3) | Gated red |
| green_o | output | GRN_W (3) | Gated green |
| blue_o | output | BLU_W (2) | Gated blue |

## Verification
The bench builds instance u0 with a shrunken raster: an 8+2+3+2 = 15-clock line and a 4+1+2+3 = 10-line frame. A run of 2000 clocks therefore sweeps every column and row position through more than thirteen whole frames. This makes every porch and sync boundary, every line and frame wrap, and each start-of-frame strobe reachable many times over. A second instance, u1, keeps the default 640x480 parameters for the same 2000 clocks. It checks the real column wrap at 799, the horizontal sync edges at 656 and 752, and the first row steps, while the vertical sync stays inactive.

// File: rtl/vga_pkg.sv
package vga_pkg;

  // Interval of one raster axis that a counter position falls in.
  typedef enum logic [1:0] {
    PH_SHOW  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_PULSE = 2'd2,
    PH_TRAIL = 2'd3
  } axis_phase_t;

endpackage

// File: rtl/vga_axis.sv
module vga_axis
  import vga_pkg::*;
#(
  parameter int VIS  = 640,
  parameter int FP   = 16,
  parameter int SYNC = 96,
  parameter int BP   = 48,
  localparam int TOT = VIS + FP + SYNC + BP,
  localparam int W   = $clog2(TOT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] pos,
  output logic         last,
  output logic         show,
  output logic         pulse
);

  localparam logic [W-1:0] LEAD_AT  = W'(VIS);
  localparam logic [W-1:0] PULSE_AT = W'(VIS + FP);
  localparam logic [W-1:0] TRAIL_AT = W'(VIS + FP + SYNC);
  localparam logic [W-1:0] LAST_AT  = W'(TOT - 1);

  axis_phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (adv) begin
      pos <= last ? '0 : pos + 1'b1;
    end
  end

  always_comb begin
    if (pos < LEAD_AT)       phase = PH_SHOW;
    else if (pos < PULSE_AT) phase = PH_LEAD;
    else if (pos < TRAIL_AT) phase = PH_PULSE;
    else                     phase = PH_TRAIL;
  end

  assign last  = (pos == LAST_AT);
  assign show  = (phase == PH_SHOW);
  assign pulse = (phase == PH_PULSE);

endmodule

// File: rtl/vga_rgb_gate.sv
module vga_rgb_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         show,
  input  logic [W-1:0] pix_i,
  output logic [W-1:0] pix_o
);

  always_ff @(posedge clk) begin
    if (rst)       pix_o <= '0;
    else if (show) pix_o <= pix_i;
    else           pix_o <= '0;
  end

endmodule

// File: rtl/vga_raster_timing.sv
module vga_raster_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 29,
  parameter int RED_W  = 3,
  parameter int GRN_W  = 3,
  parameter int BLU_W  = 2,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int CW    = $clog2(H_TOT),
  localparam int RW    = $clog2(V_TOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RED_W-1:0] red_i,
  input  logic [GRN_W-1:0] green_i,
  input  logic [BLU_W-1:0] blue_i,
  output logic [CW-1:0]    col_o,
  output logic [RW-1:0]    row_o,
  output logic             de_o,
  output logic             hsync_n_o,
  output logic             vsync_n_o,
  output logic             sof_o,
  output logic [RED_W-1:0] red_o,
  output logic [GRN_W-1:0] green_o,
  output logic [BLU_W-1:0] blue_o
);

  localparam int PW = RED_W + GRN_W + BLU_W;

  logic [CW-1:0] h_pos;
  logic [RW-1:0] v_pos;
  logic          h_last, h_show, h_pulse;
  logic          v_last, v_show, v_pulse;
  logic          show_now;
  logic [PW-1:0] pix_out;

  vga_axis #(.VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) u_haxis (
    .clk  (clk),
    .rst  (rst),
    .adv  (1'b1),
    .pos  (h_pos),
    .last (h_last),
    .show (h_show),
    .pulse(h_pulse)
  );

  vga_axis #(.VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) u_vaxis (
    .clk  (clk),
    .rst  (rst),
    .adv  (h_last),
    .pos  (v_pos),
    .last (v_last),
    .show (v_show),
    .pulse(v_pulse)
  );

  assign show_now = h_show & v_show;

  vga_rgb_gate #(.W(PW)) u_gate (
    .clk  (clk),
    .rst  (rst),
    .show (show_now),
    .pix_i({red_i, green_i, blue_i}),
    .pix_o(pix_out)
  );

  assign {red_o, green_o, blue_o} = pix_out;

  // Output stage: one register per signal, all describing the same position.
  always_ff @(posedge clk) begin
    if (rst) begin
      col_o     <= CW'(H_TOT - 1);
      row_o     <= RW'(V_TOT - 1);
      de_o      <= 1'b0;
      hsync_n_o <= 1'b1;
      vsync_n_o <= 1'b1;
      sof_o     <= 1'b0;
    end else begin
      col_o     <= h_pos;
      row_o     <= v_pos;
      de_o      <= show_now;
      hsync_n_o <= ~h_pulse;
      vsync_n_o <= ~v_pulse;
      sof_o     <= (h_pos == '0) && (v_pos == '0);
    end
  end

  logic unused_last;
  assign unused_last = v_last;

endmodule

// File: rtl/vga_raster_timing_chk.sv
module vga_raster_timing_chk #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 29,
  parameter int RED_W  = 3,
  parameter int GRN_W  = 3,
  parameter int BLU_W  = 2,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int CW    = $clog2(H_TOT),
  localparam int RW    = $clog2(V_TOT)
) (
  input logic             clk,
  input logic             rst,
  input logic [CW-1:0]    col_o,
  input logic [RW-1:0]    row_o,
  input logic             de_o,
  input logic             hsync_n_o,
  input logic             vsync_n_o,
  input logic             sof_o,
  input logic [RED_W-1:0] red_o,
  input logic [GRN_W-1:0] green_o,
  input logic [BLU_W-1:0] blue_o
);

  localparam logic [CW-1:0] C_LAST = CW'(H_TOT - 1);
  localparam logic [RW-1:0] R_LAST = RW'(V_TOT - 1);
  localparam logic [CW-1:0] C_VIS  = CW'(H_VIS);
  localparam logic [RW-1:0] R_VIS  = RW'(V_VIS);
  localparam logic [CW-1:0] HS_LO  = CW'(H_VIS + H_FP);
  localparam logic [CW-1:0] HS_HI  = CW'(H_VIS + H_FP + H_SYNC);
  localparam logic [RW-1:0] VS_LO  = RW'(V_VIS + V_FP);
  localparam logic [RW-1:0] VS_HI  = RW'(V_VIS + V_FP + V_SYNC);

  a_r1_col_wrap: assert property (@(posedge clk) disable iff (rst)
    (col_o == C_LAST) |=> (col_o == '0));

  a_r1_col_step: assert property (@(posedge clk) disable iff (rst)
    (col_o != C_LAST) |=> (col_o == CW'($past(col_o) + 1'b1)));

  a_r2_row_hold: assert property (@(posedge clk) disable iff (rst)
    (col_o != C_LAST) |=> $stable(row_o));

  a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
    (col_o == C_LAST && row_o != R_LAST) |=> (row_o == RW'($past(row_o) + 1'b1)));

  a_r2_row_wrap: assert property (@(posedge clk) disable iff (rst)
    (col_o == C_LAST && row_o == R_LAST) |=> (row_o == '0));

  a_r3_de_window: assert property (@(posedge clk) disable iff (rst)
    de_o == ((col_o < C_VIS) && (row_o < R_VIS)));

  a_r4_hsync_window: assert property (@(posedge clk) disable iff (rst)
    (!hsync_n_o) == ((col_o >= HS_LO) && (col_o < HS_HI)));

  a_r5_vsync_window: assert property (@(posedge clk) disable iff (rst)
    (!vsync_n_o) == ((row_o >= VS_LO) && (row_o < VS_HI)));

  a_r6_blank_colour: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> ({red_o, green_o, blue_o} == '0));

  a_r7_sof_position: assert property (@(posedge clk) disable iff (rst)
    sof_o == ((col_o == '0) && (row_o == '0)));

  a_r8_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!de_o && hsync_n_o && vsync_n_o && !sof_o));

endmodule

bind vga_raster_timing vga_raster_timing_chk #(
  .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
  .RED_W(RED_W), .GRN_W(GRN_W), .BLU_W(BLU_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .col_o    (col_o),
  .row_o    (row_o),
  .de_o     (de_o),
  .hsync_n_o(hsync_n_o),
  .vsync_n_o(vsync_n_o),
  .sof_o    (sof_o),
  .red_o    (red_o),
  .green_o  (green_o),
  .blue_o   (blue_o)
);

// File: tb/sim_vga_raster_timing.sv
module sim_vga_raster_timing;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 2000;

  // Shrunken raster for u0
  localparam int S_HV = 8, S_HF = 2, S_HS = 3, S_HB = 2;
  localparam int S_VV = 4, S_VF = 1, S_VS = 2, S_VB = 3;
  localparam int S_HT = S_HV + S_HF + S_HS + S_HB;   // 15
  localparam int S_VT = S_VV + S_VF + S_VS + S_VB;   // 10
  localparam int S_CW = $clog2(S_HT);
  localparam int S_RW = $clog2(S_VT);

  // Default raster for u1
  localparam int D_HT = 800;
  localparam int D_VT = 521;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] red_i   = '0;
  logic [2:0] green_i = '0;
  logic [1:0] blue_i  = '0;

  logic [S_CW-1:0] s_col;
  logic [S_RW-1:0] s_row;
  logic s_de, s_hs, s_vs, s_sof;
  logic [2:0] s_r, s_g;
  logic [1:0] s_b;

  logic [9:0] d_col;
  logic [9:0] d_row;
  logic d_de, d_hs, d_vs, d_sof;
  logic [2:0] d_r, d_g;
  logic [1:0] d_b;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vga_raster_timing #(
    .H_VIS(S_HV), .H_FP(S_HF), .H_SYNC(S_HS), .H_BP(S_HB),
    .V_VIS(S_VV), .V_FP(S_VF), .V_SYNC(S_VS), .V_BP(S_VB)
  ) u0 (
    .clk(clk), .rst(rst), .red_i(red_i), .green_i(green_i), .blue_i(blue_i),
    .col_o(s_col), .row_o(s_row), .de_o(s_de), .hsync_n_o(s_hs),
    .vsync_n_o(s_vs), .sof_o(s_sof), .red_o(s_r), .green_o(s_g), .blue_o(s_b)
  );

  vga_raster_timing u1 (
    .clk(clk), .rst(rst), .red_i(red_i), .green_i(green_i), .blue_i(blue_i),
    .col_o(d_col), .row_o(d_row), .de_o(d_de), .hsync_n_o(d_hs),
    .vsync_n_o(d_vs), .sof_o(d_sof), .red_o(d_r), .green_o(d_g), .blue_o(d_b)
  );

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d at %0t", what, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] pattern(input int k);
    return 8'((k * 37) ^ 8'hA5);
  endfunction

  initial begin : stim
    logic [7:0] prev;
    // R8: reset state with non-zero colour on the inputs
    {red_i, green_i, blue_i} = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 u0 col", int'(s_col), S_HT - 1);
    chk("R8 u0 row", int'(s_row), S_VT - 1);
    chk("R8 u0 de", int'(s_de), 0);
    chk("R8 u0 hsync", int'(s_hs), 1);
    chk("R8 u0 vsync", int'(s_vs), 1);
    chk("R8 u0 sof", int'(s_sof), 0);
    chk("R8 u0 colour", int'({s_r, s_g, s_b}), 0);
    chk("R8 u1 col", int'(d_col), D_HT - 1);
    chk("R8 u1 row", int'(d_row), D_VT - 1);

    rst = 1'b0;
    prev = pattern(0);
    {red_i, green_i, blue_i} = prev;
    for (int k = 1; k <= RUN_CYCLES; k++) begin
      @(negedge clk);
      begin
        int idx, ec, er, ed, dc, dr, dd;
        idx = (k - 1) % (S_HT * S_VT);
        ec = idx % S_HT;
        er = idx / S_HT;
        ed = (ec < S_HV && er < S_VV) ? 1 : 0;
        chk("R1 u0 col", int'(s_col), ec);
        chk("R2 u0 row", int'(s_row), er);
        chk("R3 u0 de", int'(s_de), ed);
        chk("R4 u0 hsync_n", int'(s_hs),
            (ec >= S_HV + S_HF && ec < S_HV + S_HF + S_HS) ? 0 : 1);
        chk("R5 u0 vsync_n", int'(s_vs),
            (er >= S_VV + S_VF && er < S_VV + S_VF + S_VS) ? 0 : 1);
        chk("R6 u0 colour", int'({s_r, s_g, s_b}), ed ? int'(prev) : 0);
        chk("R7 u0 sof", int'(s_sof), (ec == 0 && er == 0) ? 1 : 0);

        dc = (k - 1) % D_HT;
        dr = (k - 1) / D_HT;
        dd = (dc < 640 && dr < 480) ? 1 : 0;
        chk("R1 u1 col", int'(d_col), dc);
        chk("R2 u1 row", int'(d_row), dr);
        chk("R3 u1 de", int'(d_de), dd);
        chk("R4 u1 hsync_n", int'(d_hs), (dc >= 656 && dc < 752) ? 0 : 1);
        chk("R5 u1 vsync_n", int'(d_vs), 1);
        chk("R6 u1 colour", int'({d_r, d_g, d_b}), dd ? int'(prev) : 0);
        chk("R7 u1 sof", int'(d_sof), (k == 1) ? 1 : 0);
      end
      prev = pattern(k);
      {red_i, green_i, blue_i} = prev;
    end

    // R8: reset re-entered mid-frame returns to idle; restart is at (0,0)
    rst = 1'b1;
    @(negedge clk);
    chk("R8 u0 re-reset col", int'(s_col), S_HT - 1);
    chk("R8 u0 re-reset de", int'(s_de), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 u0 restart col", int'(s_col), 0);
    chk("R8 u0 restart row", int'(s_row), 0);
    chk("R7 u0 restart sof", int'(s_sof), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule